// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block serves a bank of general-purpose pins through a word-wide register interface. The host configures each pin in one of three roles: a plain input, a plain output, or an interrupt source. It can read the real pin levels at any time. Pin inputs pass through a two-stage synchronizer before any logic uses them, so the pins may be driven by asynchronous sources.

An interrupt pin is watched by a per-pin detector. The detector senses either a level or an edge. A polarity bit picks high or low level, or rising or falling edge, and a both-edge bit makes an edge pin trigger on either transition. Edge events are latched until the host clears them with a write-one-to-clear word. Level status follows the synchronized pin and cannot be cleared. The status is masked by an enable word that can be loaded whole or set bit by bit, and the surviving bits are ORed into one interrupt line.

The register decode and the storage/detection datapath are separate modules. The decode hands the datapath a small set of write strobes and a read selector.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, the interrupt output is low and no pin is driven (output enable all 0).
- R2: A pin whose mode bit (offset 0x00) is 0 and whose direction bit (offset 0x04) is 1 is driven with its bit of the output word (offset 0x08, read/write). It is not driven when its mode bit is 1 (interrupt role) or when its source-select bit (offset 0x40) is 1.
- R3: The input word (offset 0x0C) returns the synchronized pin level ANDed with the input enable word (offset 0x50). This holds for pins configured as outputs too.
- R4: With sense bit 0 (offset 0x24, level), the status bit (offset 0x10) of an interrupt pin is 1 while the pin is high (polarity bit 0, offset 0x20) or low (polarity bit 1). Writing the clear word does not remove it.
- R5: With sense bit 1 (edge) and both-edge bit 0 (offset 0x4C), polarity 0 latches status on a rising edge and polarity 1 latches it on a falling edge. The status stays set after the pin returns.
- R6: With sense bit 1 and both-edge bit 1, either edge latches status.
- R7: Writing 1 to a bit of the clear word (offset 0x14) clears that pin's latched edge status, and 0 bits have no effect. If a new edge arrives in the same cycle as the clear, the edge wins and the status stays set.
- R8: The interrupt output is high exactly when status AND mask (offset 0x18, 1 = enabled) is nonzero. A write to the mask offset loads the whole word.
- R9: Writing 1 to a bit of the unmask word (offset 0x1C) sets that mask bit and leaves the other mask bits unchanged.
- R10: A pin whose input enable bit is 0 reads 0 in the input word and latches no edge status.
- R11: Reads of the clear word, the unmask word and any unmapped offset return 0. Writes to an unmapped offset change no register.
- R12: A pin in the general I/O role (mode bit 0) shows status 0 regardless of its sense, polarity and pin activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid in the cycle rdEn is high |
| pinIn | input | PINS | Pin levels from the pads |
| pinOut | output | PINS | Output levels to the pads |
| pinOe | output | PINS | Output enables to the pads |
| irqOut | output | 1 | Combined interrupt to the host |

## Verification
The clear-word write and a freshly detected edge can land on the same pin in the same clock. The bench changes a both-edge pin so that its synchronized edge reaches the detector in exactly the cycle the clear write is sampled, and then expects the status bit to read back as still set. Mask and unmask writes are judged through both the mask read-back and the interrupt pin while an edge status is pending.

// File: rtl/gib_pkg.sv
package gib_pkg;

  localparam int unsigned OFS_MODE   = 'h00;
  localparam int unsigned OFS_DIR    = 'h04;
  localparam int unsigned OFS_OUT    = 'h08;
  localparam int unsigned OFS_IN     = 'h0C;
  localparam int unsigned OFS_STAT   = 'h10;
  localparam int unsigned OFS_CLR    = 'h14;
  localparam int unsigned OFS_MASK   = 'h18;
  localparam int unsigned OFS_UNMASK = 'h1C;
  localparam int unsigned OFS_POL    = 'h20;
  localparam int unsigned OFS_SENSE  = 'h24;
  localparam int unsigned OFS_SRC    = 'h40;
  localparam int unsigned OFS_BOTH   = 'h4C;
  localparam int unsigned OFS_INEN   = 'h50;

  typedef struct packed {
    logic wrMode;
    logic wrDir;
    logic wrOut;
    logic wrClr;
    logic wrMask;
    logic wrUnmask;
    logic wrPol;
    logic wrSense;
    logic wrSrc;
    logic wrBoth;
    logic wrInEn;
  } gibWrStrobes_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_MODE, RD_DIR, RD_OUT, RD_IN, RD_STAT, RD_MASK,
    RD_POL, RD_SENSE, RD_SRC, RD_BOTH, RD_INEN
  } gibRdSel_t;

endpackage

// File: rtl/gib_ctrl.sv
module gib_ctrl
  import gib_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output gibWrStrobes_t     wrStb,
  output gibRdSel_t         rdSel
);

  gibRdSel_t rdPick;

  always_comb begin
    wrStb  = '0;
    rdPick = RD_NONE;
    case (addr)
      ADDR_W'(OFS_MODE):   begin wrStb.wrMode   = wrEn; rdPick = RD_MODE;  end
      ADDR_W'(OFS_DIR):    begin wrStb.wrDir    = wrEn; rdPick = RD_DIR;   end
      ADDR_W'(OFS_OUT):    begin wrStb.wrOut    = wrEn; rdPick = RD_OUT;   end
      ADDR_W'(OFS_IN):     rdPick = RD_IN;
      ADDR_W'(OFS_STAT):   rdPick = RD_STAT;
      ADDR_W'(OFS_CLR):    wrStb.wrClr = wrEn;
      ADDR_W'(OFS_MASK):   begin wrStb.wrMask   = wrEn; rdPick = RD_MASK;  end
      ADDR_W'(OFS_UNMASK): wrStb.wrUnmask = wrEn;
      ADDR_W'(OFS_POL):    begin wrStb.wrPol    = wrEn; rdPick = RD_POL;   end
      ADDR_W'(OFS_SENSE):  begin wrStb.wrSense  = wrEn; rdPick = RD_SENSE; end
      ADDR_W'(OFS_SRC):    begin wrStb.wrSrc    = wrEn; rdPick = RD_SRC;   end
      ADDR_W'(OFS_BOTH):   begin wrStb.wrBoth   = wrEn; rdPick = RD_BOTH;  end
      ADDR_W'(OFS_INEN):   begin wrStb.wrInEn   = wrEn; rdPick = RD_INEN;  end
      default: ;
    endcase
    rdSel = rdEn ? rdPick : RD_NONE;
  end

endmodule

// File: rtl/gib_datapath.sv
module gib_datapath
  import gib_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  gibWrStrobes_t     wrStb,
  input  gibRdSel_t         rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PINS-1:0]   pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut,
  output logic [PINS-1:0]   modeQ,
  output logic [PINS-1:0]   maskQ,
  output logic [PINS-1:0]   latchQ,
  output logic [PINS-1:0]   hitQ,
  output logic [PINS-1:0]   inEnQ
);

  logic [PINS-1:0] wrBits;
  logic [PINS-1:0] dirQ, outQ, polQ, senseQ, srcQ, bothQ;
  logic [PINS-1:0] syncA, syncB, prevB;
  logic [PINS-1:0] levelHit, statusW, rdWord;

  assign wrBits = wrData[PINS-1:0];

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0; dirQ   <= '0; outQ  <= '0; maskQ <= '0;
      polQ   <= '0; senseQ <= '0; srcQ  <= '0; bothQ <= '0;
      inEnQ  <= '0;
    end else begin
      if (wrStb.wrMode)  modeQ  <= wrBits;
      if (wrStb.wrDir)   dirQ   <= wrBits;
      if (wrStb.wrOut)   outQ   <= wrBits;
      if (wrStb.wrPol)   polQ   <= wrBits;
      if (wrStb.wrSense) senseQ <= wrBits;
      if (wrStb.wrSrc)   srcQ   <= wrBits;
      if (wrStb.wrBoth)  bothQ  <= wrBits;
      if (wrStb.wrInEn)  inEnQ  <= wrBits;
      if (wrStb.wrMask)        maskQ <= wrBits;
      else if (wrStb.wrUnmask) maskQ <= maskQ | wrBits;
    end
  end

  // input synchronizer and previous sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // per-pin detector
  for (genvar i = 0; i < PINS; i++) begin : g_det
    logic rise, fall, sel;
    assign rise = syncB[i] & ~prevB[i];
    assign fall = ~syncB[i] & prevB[i];
    assign sel  = bothQ[i] ? (rise | fall) : (polQ[i] ? fall : rise);
    assign hitQ[i]     = inEnQ[i] & modeQ[i] & senseQ[i] & sel;
    assign levelHit[i] = inEnQ[i] & (syncB[i] ^ polQ[i]);
    assign statusW[i]  = modeQ[i] & (senseQ[i] ? latchQ[i] : levelHit[i]);
  end

  // edge latch: a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else latchQ <= (latchQ & ~(wrStb.wrClr ? wrBits : '0)) | hitQ;
  end

  assign irqOut = |(statusW & maskQ);
  assign pinOe  = ~modeQ & dirQ & ~srcQ;
  assign pinOut = outQ;

  always_comb begin
    case (rdSel)
      RD_MODE:  rdWord = modeQ;
      RD_DIR:   rdWord = dirQ;
      RD_OUT:   rdWord = outQ;
      RD_IN:    rdWord = syncB & inEnQ;
      RD_STAT:  rdWord = statusW;
      RD_MASK:  rdWord = maskQ;
      RD_POL:   rdWord = polQ;
      RD_SENSE: rdWord = senseQ;
      RD_SRC:   rdWord = srcQ;
      RD_BOTH:  rdWord = bothQ;
      RD_INEN:  rdWord = inEnQ;
      default:  rdWord = '0;
    endcase
    rdData = '0;
    rdData[PINS-1:0] = rdWord;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);

  gibWrStrobes_t   wrStb;
  gibRdSel_t       rdSel;
  logic [PINS-1:0] modeQ, maskQ, latchQ, hitQ, inEnQ;

  gib_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrStb(wrStb), .rdSel(rdSel)
  );

  gib_datapath #(.PINS(PINS), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdSel(rdSel), .wrData(wrData),
    .pinIn(pinIn), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut), .modeQ(modeQ), .maskQ(maskQ), .latchQ(latchQ),
    .hitQ(hitQ), .inEnQ(inEnQ)
  );

endmodule

// File: rtl/gib_checker.sv
module gib_checker #(
  parameter int PINS   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [PINS-1:0]   pinOe,
  input logic              irqOut,
  input logic [PINS-1:0]   modeQ,
  input logic [PINS-1:0]   maskQ,
  input logic [PINS-1:0]   latchQ,
  input logic [PINS-1:0]   hitQ,
  input logic [PINS-1:0]   inEnQ
);

  assert_no_drive_on_irq_pin_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & modeQ) == '0);

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('h18)) |=> maskQ == $past(wrData[PINS-1:0]));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);

  assert_unmask_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('h1C)) |=> maskQ == ($past(maskQ) | $past(wrData[PINS-1:0])));

  assert_latch_needs_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (latchQ & ~($past(latchQ) | $past(hitQ))) == '0);

  assert_disabled_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'('h0C)) |-> (rdData[PINS-1:0] & ~inEnQ) == '0);

endmodule

bind gpio_irq_bank gib_checker #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .pinOe(pinOe), .irqOut(irqOut), .modeQ(modeQ), .maskQ(maskQ),
  .latchQ(latchQ), .hitQ(hitQ), .inEnQ(inEnQ)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

  localparam int PINS = 32;
  localparam int DW   = 32;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [PINS-1:0] pinIn = '0, pinOut, pinOe;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.PINS(PINS), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  // monitor: compares every read against the scoreboard
  always @(negedge clk) begin
    if (rdEn) begin
      item_t it;
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: unexpected read at 0x%02h actual=0x%08h expected=none", addr, rdData);
      end else begin
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          failures++;
          $display("FAIL %s: read 0x%02h actual=0x%08h expected=0x%08h", it.tag, it.a, rdData, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdExp(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.a = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    rdEn = 1'b1; addr = a;
    @(negedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic checkVal(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, e);
    end
  endtask

  task automatic setPins(input logic [PINS-1:0] v);
    @(posedge clk); #1;
    pinIn = v;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkVal("R1 irq", DW'(irqOut), 0);
    checkVal("R1 oe", DW'(pinOe), 0);
    rdExp(8'h00, 0, "R1"); rdExp(8'h04, 0, "R1"); rdExp(8'h08, 0, "R1");
    rdExp(8'h18, 0, "R1"); rdExp(8'h24, 0, "R1"); rdExp(8'h50, 0, "R1");

    // R2 output driving
    wr(8'h04, 32'h0F);
    wr(8'h08, 32'hA5);
    checkVal("R2 oe", DW'(pinOe), 32'h0F);
    checkVal("R2 out", DW'(pinOut), 32'hA5);
    rdExp(8'h08, 32'hA5, "R2");
    wr(8'h40, 32'h01);
    checkVal("R2 src release", DW'(pinOe), 32'h0E);
    wr(8'h00, 32'h02);
    checkVal("R2 irq role release", DW'(pinOe), 32'h0C);
    wr(8'h00, 0); wr(8'h40, 0); wr(8'h08, 0);

    // R10 disabled inputs, then R3 readback including an output pin
    setPins(32'hFF);
    rdExp(8'h0C, 0, "R10");
    wr(8'h50, 32'hFFFF_FFFF);
    rdExp(8'h0C, 32'hFF, "R3");
    checkVal("R3 output pin driven low", DW'(pinOe & pinOut), 0);
    rdExp(8'h0C, 32'hFF, "R3 output pin real level");
    wr(8'h04, 0);
    setPins(0);

    // R4 level high on pin0 and level low on pin1
    wr(8'h18, 32'h3);
    wr(8'h00, 32'h1);
    setPins(32'h1);
    rdExp(8'h10, 32'h1, "R4");
    checkVal("R8 irq level", DW'(irqOut), 1);
    wr(8'h14, 32'h1);
    rdExp(8'h10, 32'h1, "R4 not clearable");
    setPins(0);
    rdExp(8'h10, 0, "R4");
    checkVal("R8 irq drop", DW'(irqOut), 0);
    wr(8'h20, 32'h2);
    wr(8'h00, 32'h2);
    #1 rdExp(8'h10, 32'h2, "R4 active low");
    setPins(32'h2);
    rdExp(8'h10, 0, "R4 active low released");
    wr(8'h00, 0); wr(8'h20, 0);
    setPins(0);

    // R5 rising on pin2
    wr(8'h24, 32'h4);
    wr(8'h00, 32'h4);
    setPins(32'h4);
    rdExp(8'h10, 32'h4, "R5 rise");
    setPins(0);
    rdExp(8'h10, 32'h4, "R5 latched");
    wr(8'h14, 0);
    rdExp(8'h10, 32'h4, "R7 zero bits");
    wr(8'h14, 32'h4);
    rdExp(8'h10, 0, "R7 clear");

    // R5 falling on pin3
    wr(8'h24, 32'h0C); wr(8'h20, 32'h08); wr(8'h00, 32'h0C);
    setPins(32'h8);
    rdExp(8'h10, 0, "R5 falling ignores rise");
    setPins(0);
    rdExp(8'h10, 32'h8, "R5 fall");
    wr(8'h14, 32'h8);

    // R6 both edges on pin4
    wr(8'h20, 0); wr(8'h24, 32'h10); wr(8'h4C, 32'h10); wr(8'h00, 32'h10);
    setPins(32'h10);
    rdExp(8'h10, 32'h10, "R6 rise");
    wr(8'h14, 32'h10);
    setPins(0);
    rdExp(8'h10, 32'h10, "R6 fall");
    wr(8'h14, 32'h10);
    setPins(32'h10);

    // R8 / R9 masking with pin4 pending
    wr(8'h18, 0);
    checkVal("R8 all masked", DW'(irqOut), 0);
    wr(8'h18, 32'hFFFF_FFEF);
    checkVal("R8 one bit masked", DW'(irqOut), 0);
    wr(8'h1C, 32'h10);
    rdExp(8'h18, 32'hFFFF_FFFF, "R9");
    checkVal("R9 irq", DW'(irqOut), 1);
    wr(8'h18, 32'h1);
    wr(8'h1C, 32'h10);
    rdExp(8'h18, 32'h11, "R9 keeps others");
    wr(8'h14, 32'h10);
    checkVal("R7 irq after clear", DW'(irqOut), 0);

    // R7 clear and edge in the same cycle: edge wins
    @(posedge clk); #1 pinIn = 0;
    @(posedge clk);
    @(posedge clk); #1 wrEn = 1'b1; addr = 8'h14; wrData = 32'h10;
    @(posedge clk); #1 wrEn = 1'b0;
    rdExp(8'h10, 32'h10, "R7 edge wins");
    wr(8'h14, 32'h10);

    // R10 disabled pin latches nothing
    wr(8'h50, 32'hFFFF_FFEF);
    setPins(32'h10);
    rdExp(8'h10, 0, "R10 no status");
    rdExp(8'h0C, 0, "R10 reads zero");
    wr(8'h50, 32'hFFFF_FFFF);

    // R12 general I/O pin shows no status
    wr(8'h00, 0); wr(8'h24, 32'h20);
    setPins(32'h30);
    rdExp(8'h10, 0, "R12");
    setPins(32'h10);
    rdExp(8'h10, 0, "R12");

    // R11 write-only and unmapped offsets
    wr(8'h00, 32'h10);
    rdExp(8'h14, 0, "R11 clear word");
    rdExp(8'h1C, 0, "R11 unmask word");
    wr(8'h30, 32'hFFFF_FFFF);
    rdExp(8'h30, 0, "R11 unmapped");
    rdExp(8'h00, 32'h10, "R11 no side effect");
    rdExp(8'h18, 32'h11, "R11 no side effect");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule